// File: doc/BRIEF.md
# Set-Associative Address Translation Buffer

This block translates a 32-bit virtual address into a physical address and a set of read, write and execute permissions. It uses a set-associative array of translation entries. Pages are 4 KB. The upper twenty address bits form the virtual page number (VPN), and the low bits of the VPN select one set. Every way of that set is compared in parallel. An entry matches when three things hold: it is valid, its VPN equals the requested one, and either it is marked global or its stored process identifier equals the caller's. When several ways match, the lowest-numbered way wins.

A request is presented on the lookup port. It carries an address, a process identifier and an access kind. The answer is registered and appears one clock later. It gives hit, physical address, the three permission flags, and a grant bit that says whether the requested kind of access is allowed.

A separate maintenance agent fills the entries through a write port. That port names a way and supplies the VPN, identifier, global flag, frame number and permissions. The set is derived from the VPN. The number of ways, the total entry count and the identifier width are parameters. The number of ways and the number of sets must both be powers of two.

Top module: `tlb_lookup_unit`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses until an entry is written.
- R2: A lookup hits only on a valid entry whose VPN equals address bits 31:12 and whose stored identifier equals `lk_pid`, unless that entry is global. On a hit, `rsp_paddr` is the frame number in bits 31:12 and the request's address bits 11:0 in the low bits.
- R3: A global entry hits for any `lk_pid`.
- R4: The set used for both write and lookup is the VPN ANDed with (sets − 1). Entries of one set in different ways coexist, and a VPN that selects a set but does not equal the stored VPN misses.
- R5: When more than one way matches, the result comes from the lowest-numbered matching way.
- R6: On a miss, or when no response is valid, `rsp_paddr`, `rsp_r`, `rsp_w`, `rsp_x` and `rsp_grant` are zero.
- R7: `rsp_r`, `rsp_w` and `rsp_x` are the read, write and execute flags written with the hitting entry.
- R8: `lk_kind` encodes 0 = read, 1 = write, 2 = instruction fetch, 3 = reserved. `rsp_grant` is 1 only on a hit whose flag for that kind is set, and never for kind 3.
- R9: An entry written with VPN bits 19:18 both 1 (addresses 0xC0000000 and up) is stored invalid and never hits.
- R10: `rsp_valid` is `lk_valid` delayed by one clock. `rsp_hit` is never 1 without `rsp_valid`.
- R11: Writing a way and set that already holds an entry replaces that entry completely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_pid | input | PID_W | Current process identifier |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 reserved |
| wr_en | input | 1 | Write one entry this cycle |
| wr_way | input | WAY_W | Way to write |
| wr_vpn | input | 20 | VPN of the new entry (also selects the set) |
| wr_pid | input | PID_W | Identifier of the new entry |
| wr_global | input | 1 | New entry matches any identifier |
| wr_pfn | input | 20 | Physical frame number of the new entry |
| wr_r | input | 1 | Read permission of the new entry |
| wr_w | input | 1 | Write permission of the new entry |
| wr_x | input | 1 | Execute permission of the new entry |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_hit | output | 1 | A matching entry was found |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_r | output | 1 | Read permission of the hit |
| rsp_w | output | 1 | Write permission of the hit |
| rsp_x | output | 1 | Execute permission of the hit |
| rsp_grant | output | 1 | Requested access kind is permitted |

## Verification
A corrupted stored tag shows up on the very next lookup that indexes its set. It appears either as a spurious miss or as a hit carrying the wrong frame number, one clock after the request. A broken way-priority or set-index path is visible only when two ways hold the same VPN, or when two VPNs share low bits, so the stimulus deliberately creates both cases. A wrong permission mux shows up as a grant that disagrees with the returned flag for that access kind, again on the cycle after the request.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int PAGE_BITS = 12;
    localparam int VPN_W     = 32 - PAGE_BITS;
    localparam int PFN_W     = 20;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_t;

    typedef struct packed {
        logic [PFN_W-1:0] pfn;
        logic             r;
        logic             w;
        logic             x;
    } tlb_data_t;

    // VPNs whose two top bits are both set cannot be mapped (R9)
    function automatic logic vpn_mappable(input logic [VPN_W-1:0] vpn);
        return !(vpn[VPN_W-1] && vpn[VPN_W-2]);
    endfunction
endpackage

// File: rtl/tlb_tag_cmp.sv
module tlb_tag_cmp #(
    parameter int PID_W = 8
) (
    input  logic [tlb_pkg::VPN_W-1:0] tag_vpn,
    input  logic                      tag_glb,
    input  logic                      tag_vld,
    input  logic [PID_W-1:0]          tag_pid,
    input  logic [tlb_pkg::VPN_W-1:0] req_vpn,
    input  logic [PID_W-1:0]          req_pid,
    output logic                      match
);
    logic vpn_eq;
    logic pid_ok;

    always_comb begin
        vpn_eq = (tag_vpn == req_vpn);
        pid_ok = tag_glb || (tag_pid == req_pid);
        match  = tag_vld && vpn_eq && pid_ok;
    end
endmodule

// File: rtl/tlb_way_pick.sv
module tlb_way_pick #(
    parameter int  N     = 2,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     match,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |match;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) begin
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tlb_perm_gate.sv
module tlb_perm_gate (
    input  logic       hit,
    input  logic [1:0] kind,
    input  logic       r,
    input  logic       w,
    input  logic       x,
    output logic       grant
);
    import tlb_pkg::*;

    acc_kind_t k;

    always_comb begin
        k = acc_kind_t'(kind);
        unique case (k)
            ACC_LOAD:  grant = hit && r;
            ACC_STORE: grant = hit && w;
            ACC_FETCH: grant = hit && x;
            default:   grant = 1'b0;
        endcase
    end
endmodule

// File: rtl/tlb_lookup_unit.sv
module tlb_lookup_unit #(
    parameter int  NUM_WAYS    = 2,
    parameter int  NUM_ENTRIES = 16,
    parameter int  PID_W       = 8,
    localparam int WAY_W       = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 lk_valid,
    input  logic [31:0]          lk_vaddr,
    input  logic [PID_W-1:0]     lk_pid,
    input  logic [1:0]           lk_kind,
    input  logic                 wr_en,
    input  logic [WAY_W-1:0]     wr_way,
    input  logic [19:0]          wr_vpn,
    input  logic [PID_W-1:0]     wr_pid,
    input  logic                 wr_global,
    input  logic [19:0]          wr_pfn,
    input  logic                 wr_r,
    input  logic                 wr_w,
    input  logic                 wr_x,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic [31:0]          rsp_paddr,
    output logic                 rsp_r,
    output logic                 rsp_w,
    output logic                 rsp_x,
    output logic                 rsp_grant
);
    import tlb_pkg::*;

    localparam int SETS  = NUM_ENTRIES / NUM_WAYS;
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1;

    // tag word: VPN on top, then global, then valid, identifier at the bottom
    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic             glb;
        logic             vld;
        logic [PID_W-1:0] pid;
    } tag_t;

    typedef struct packed {
        tag_t      [NUM_WAYS-1:0][SETS-1:0] tags;
        tlb_data_t [NUM_WAYS-1:0][SETS-1:0] data;
        logic                               rsp_valid;
        logic                               rsp_hit;
        logic [31:0]                        rsp_paddr;
        logic                               rsp_r;
        logic                               rsp_w;
        logic                               rsp_x;
        logic                               rsp_grant;
    } state_t;

    state_t state_d, state_q;

    logic [VPN_W-1:0]    lk_vpn;
    logic [VPN_W-1:0]    lk_set_full;
    logic [SET_W-1:0]    lk_set;
    logic [VPN_W-1:0]    wr_set_full;
    logic [SET_W-1:0]    wr_set;
    tag_t                new_tag;
    tlb_data_t           new_data;

    tag_t      [NUM_WAYS-1:0] rd_tag;
    tlb_data_t [NUM_WAYS-1:0] rd_data;
    logic      [NUM_WAYS-1:0] way_match;
    logic                     any_hit;
    logic      [WAY_W-1:0]    hit_way;
    tlb_data_t                hit_data;
    logic                     grant_c;

    // index derivation: VPN masked by (sets - 1) (R4)
    always_comb begin
        lk_vpn      = lk_vaddr[31:PAGE_BITS];
        lk_set_full = lk_vpn & VPN_W'(SETS - 1);
        lk_set      = lk_set_full[SET_W-1:0];
        wr_set_full = wr_vpn & VPN_W'(SETS - 1);
        wr_set      = wr_set_full[SET_W-1:0];
    end

    // per-way read and compare of the indexed set
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        always_comb begin
            rd_tag[w]  = state_q.tags[w][lk_set];
            rd_data[w] = state_q.data[w][lk_set];
        end

        tlb_tag_cmp #(.PID_W(PID_W)) cmp_i (
            .tag_vpn (rd_tag[w].vpn),
            .tag_glb (rd_tag[w].glb),
            .tag_vld (rd_tag[w].vld),
            .tag_pid (rd_tag[w].pid),
            .req_vpn (lk_vpn),
            .req_pid (lk_pid),
            .match   (way_match[w])
        );
    end

    tlb_way_pick #(.N(NUM_WAYS)) pick_i (
        .match (way_match),
        .any   (any_hit),
        .idx   (hit_way)
    );

    always_comb begin
        hit_data = rd_data[hit_way];
    end

    tlb_perm_gate gate_i (
        .hit   (any_hit),
        .kind  (lk_kind),
        .r     (hit_data.r),
        .w     (hit_data.w),
        .x     (hit_data.x),
        .grant (grant_c)
    );

    always_comb begin
        new_tag.vpn   = wr_vpn;
        new_tag.glb   = wr_global;
        new_tag.vld   = vpn_mappable(wr_vpn);
        new_tag.pid   = wr_pid;
        new_data.pfn  = wr_pfn;
        new_data.r    = wr_r;
        new_data.w    = wr_w;
        new_data.x    = wr_x;

        state_d = state_q;

        if (wr_en) begin
            state_d.tags[wr_way][wr_set] = new_tag;
            state_d.data[wr_way][wr_set] = new_data;
        end

        state_d.rsp_valid = lk_valid;
        state_d.rsp_hit   = lk_valid && any_hit;
        if (lk_valid && any_hit) begin
            state_d.rsp_paddr = {hit_data.pfn, lk_vaddr[PAGE_BITS-1:0]};
            state_d.rsp_r     = hit_data.r;
            state_d.rsp_w     = hit_data.w;
            state_d.rsp_x     = hit_data.x;
            state_d.rsp_grant = grant_c;
        end else begin
            state_d.rsp_paddr = '0;
            state_d.rsp_r     = 1'b0;
            state_d.rsp_w     = 1'b0;
            state_d.rsp_x     = 1'b0;
            state_d.rsp_grant = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        rsp_valid = state_q.rsp_valid;
        rsp_hit   = state_q.rsp_hit;
        rsp_paddr = state_q.rsp_paddr;
        rsp_r     = state_q.rsp_r;
        rsp_w     = state_q.rsp_w;
        rsp_x     = state_q.rsp_x;
        rsp_grant = state_q.rsp_grant;
    end
endmodule

// File: rtl/tlb_lookup_chk.sv
module tlb_lookup_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        lk_valid,
    input logic [31:0] lk_vaddr,
    input logic [1:0]  lk_kind,
    input logic        rsp_valid,
    input logic        rsp_hit,
    input logic [31:0] rsp_paddr,
    input logic        rsp_r,
    input logic        rsp_w,
    input logic        rsp_x,
    input logic        rsp_grant
);
    AST_REQ_GIVES_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid); // R10
    AST_IDLE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid); // R10
    AST_HIT_NEEDS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid); // R10
    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_hit |-> (rsp_paddr == 32'd0 && !rsp_r && !rsp_w && !rsp_x && !rsp_grant)); // R6
    AST_GRANT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_grant |-> rsp_hit); // R8
    AST_RSVD_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_kind == 2'd3) |=> !rsp_grant); // R8
    AST_FETCH_NEEDS_X: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_kind == 2'd2) |=> (!rsp_grant || rsp_x)); // R7
    AST_HIGH_VPN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_vaddr[31:30] == 2'b11) |=> !rsp_hit); // R9
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (!rsp_hit || rsp_paddr[11:0] == $past(lk_vaddr[11:0]))); // R2
endmodule

bind tlb_lookup_unit tlb_lookup_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_vaddr  (lk_vaddr),
    .lk_kind   (lk_kind),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_paddr (rsp_paddr),
    .rsp_r     (rsp_r),
    .rsp_w     (rsp_w),
    .rsp_x     (rsp_x),
    .rsp_grant (rsp_grant)
);

// File: tb/tlb_lookup_unit_tb.sv
module tlb_lookup_unit_tb_top;
    localparam int PID_W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [7:0]  lk_pid = '0;
    logic [1:0]  lk_kind = '0;
    logic        wr_en = 1'b0;
    logic [0:0]  wr_way = '0;
    logic [19:0] wr_vpn = '0;
    logic [7:0]  wr_pid = '0;
    logic        wr_global = 1'b0;
    logic [19:0] wr_pfn = '0;
    logic        wr_r = 1'b0, wr_w = 1'b0, wr_x = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_r, rsp_w, rsp_x, rsp_grant;
    logic [31:0] rsp_paddr;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tlb_lookup_unit #(.NUM_WAYS(2), .NUM_ENTRIES(16), .PID_W(PID_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_pid(lk_pid), .lk_kind(lk_kind),
        .wr_en(wr_en), .wr_way(wr_way), .wr_vpn(wr_vpn), .wr_pid(wr_pid),
        .wr_global(wr_global), .wr_pfn(wr_pfn), .wr_r(wr_r), .wr_w(wr_w), .wr_x(wr_x),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
        .rsp_r(rsp_r), .rsp_w(rsp_w), .rsp_x(rsp_x), .rsp_grant(rsp_grant)
    );

    typedef struct packed {
        logic [31:0] va;
        logic [7:0]  pid;
        logic [1:0]  kind;
        logic        hit;
        logic [31:0] pa;
        logic [2:0]  rwx;
        logic        grant;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{32'h0001_2345, 8'd5,   2'd0, 1'b1, 32'h0ABC_D345, 3'b101, 1'b1, 8'd2},  // R2 private hit
        '{32'h0001_2FFF, 8'd6,   2'd0, 1'b0, 32'h0,         3'b000, 1'b0, 8'd2},  // R2 pid mismatch
        '{32'h0002_2000, 8'd0,   2'd1, 1'b1, 32'h1111_1000, 3'b110, 1'b1, 8'd3},  // R3 global
        '{32'h0002_2000, 8'hFF,  2'd2, 1'b1, 32'h1111_1000, 3'b110, 1'b0, 8'd8},  // R8 fetch w/o x
        '{32'h0001_2000, 8'd5,   2'd1, 1'b1, 32'h0ABC_D000, 3'b101, 1'b0, 8'd8},  // R8 write w/o w
        '{32'h0001_2000, 8'd5,   2'd2, 1'b1, 32'h0ABC_D000, 3'b101, 1'b1, 8'd8},  // R8 fetch ok
        '{32'h0001_2000, 8'd5,   2'd3, 1'b1, 32'h0ABC_D000, 3'b101, 1'b0, 8'd8},  // R8 reserved
        '{32'h0003_5000, 8'd5,   2'd0, 1'b1, 32'h2222_2000, 3'b111, 1'b1, 8'd5},  // R5 way 0 wins
        '{32'hC000_3000, 8'd5,   2'd0, 1'b0, 32'h0,         3'b000, 1'b0, 8'd9},  // R9 unmappable
        '{32'h0004_7010, 8'd9,   2'd2, 1'b1, 32'h6666_6010, 3'b001, 1'b1, 8'd11}, // R11 replaced
        '{32'h0001_A000, 8'd5,   2'd0, 1'b0, 32'h0,         3'b000, 1'b0, 8'd4},  // R4 same set, other vpn
        '{32'h0004_7000, 8'd8,   2'd0, 1'b0, 32'h0,         3'b000, 1'b0, 8'd2},  // R2 pid mismatch
        '{32'h0001_5000, 8'd5,   2'd0, 1'b0, 32'h0,         3'b000, 1'b0, 8'd6}   // R6 miss zeroes
    };

    task automatic do_write(input logic way, input logic [19:0] vpn, input logic [7:0] pid,
                            input logic g, input logic [19:0] pfn, input logic [2:0] rwx);
        @(negedge clk);
        wr_en = 1'b1; wr_way = way; wr_vpn = vpn; wr_pid = pid; wr_global = g;
        wr_pfn = pfn; {wr_r, wr_w, wr_x} = rwx;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // drive at a falling edge, response is registered at the next rising edge,
    // sampled at the following falling edge
    task automatic do_lookup(input logic [31:0] va, input logic [7:0] pid, input logic [1:0] kind,
                             input logic ehit, input logic [31:0] epa, input logic [2:0] erwx,
                             input logic egrant, input int req);
        @(negedge clk);
        lk_valid = 1'b1; lk_vaddr = va; lk_pid = pid; lk_kind = kind;
        @(negedge clk);
        lk_valid = 1'b0;
        total++;
        if (rsp_valid !== 1'b1 || rsp_hit !== ehit || rsp_paddr !== epa ||
            {rsp_r, rsp_w, rsp_x} !== erwx || rsp_grant !== egrant) begin
            bad++;
            $display("FAIL R%0d va=%h got v=%b hit=%b pa=%h rwx=%b g=%b exp v=1 hit=%b pa=%h rwx=%b g=%b",
                     req, va, rsp_valid, rsp_hit, rsp_paddr, {rsp_r, rsp_w, rsp_x}, rsp_grant,
                     ehit, epa, erwx, egrant);
        end
    endtask

    task automatic check_idle(input int req);
        total++;
        if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0 || rsp_paddr !== 32'h0) begin
            bad++;
            $display("FAIL R%0d idle got v=%b hit=%b pa=%h exp v=0 hit=0 pa=0",
                     req, rsp_valid, rsp_hit, rsp_paddr);
        end
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle(1);                                   // R1 reset state
        do_lookup(32'h0000_0000, 8'd0, 2'd0, 1'b0, 32'h0, 3'b000, 1'b0, 1);  // R1 empty
        do_lookup(32'h0001_2000, 8'd5, 2'd0, 1'b0, 32'h0, 3'b000, 1'b0, 1);  // R1 empty

        do_write(1'b0, 20'h00012, 8'd5, 1'b0, 20'h0ABCD, 3'b101);
        do_write(1'b1, 20'h00022, 8'd7, 1'b1, 20'h11111, 3'b110);
        do_write(1'b0, 20'h00035, 8'd5, 1'b0, 20'h22222, 3'b111);
        do_write(1'b1, 20'h00035, 8'd5, 1'b0, 20'h33333, 3'b100);
        do_write(1'b0, 20'hC0003, 8'd5, 1'b1, 20'h44444, 3'b111);
        do_write(1'b1, 20'h00047, 8'd9, 1'b0, 20'h55555, 3'b010);
        do_write(1'b1, 20'h00047, 8'd9, 1'b0, 20'h66666, 3'b001);

        for (int i = 0; i < NV; i++) begin
            do_lookup(VEC[i].va, VEC[i].pid, VEC[i].kind, VEC[i].hit, VEC[i].pa,
                      VEC[i].rwx, VEC[i].grant, int'(VEC[i].req));
        end

        // R10: no request, no response
        @(negedge clk);
        check_idle(10);

        // R7: permissions follow the entry; overwrite set 2 way 1 with read-only
        do_write(1'b1, 20'h00022, 8'd7, 1'b1, 20'h77777, 3'b100);
        do_lookup(32'h0002_2ABC, 8'd3, 2'd0, 1'b1, 32'h7777_7ABC, 3'b100, 1'b1, 7);
        // R4: way 0 of the same set still intact
        do_lookup(32'h0001_2000, 8'd5, 2'd0, 1'b1, 32'h0ABC_D000, 3'b101, 1'b1, 4);

        // R1: reset mid-run invalidates all entries
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        do_lookup(32'h0001_2000, 8'd5, 2'd0, 1'b0, 32'h0, 3'b000, 1'b0, 1);
        do_lookup(32'h0002_2000, 8'd7, 2'd0, 1'b0, 32'h0, 3'b000, 1'b0, 1);

        done = 1'b1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            summary();
        end
    end
endmodule